// File: doc/BRIEF.md
# Parallel NOR Flash Write-Command Sequencer

This block sits between a host bus and the storage side of a parallel NOR flash model. It watches single-cycle write strobes, each carrying a byte offset and a data byte, and follows the multi-cycle command protocol. That protocol starts with a two-step unlock handshake, continues with a command cycle, and ends with any follow-on cycles. Sequences that are complete and valid become program or erase requests. Each request is held until the storage side acknowledges it. The block also switches the read path into an identification mode or a query-table mode.

The two unlock addresses are not fixed. They are sampled from configuration pins while reset is held and kept until the next reset. Every address check in the protocol uses the captured values. A bypass mode lets programming proceed without repeating the handshake. A reset command and any malformed cycle both return the machine to idle with the read path in normal array mode.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst` is high the block samples `cfg_unlock0` and `cfg_unlock1`. After reset the outputs are as follows: `rd_mode` = 0 (array), `rd_data` = 0, and `prog_req`, `erase_req` and `busy` are all low. Bypass mode is off.
- R2: From idle, with bypass off, a write of data 0xAA to the captured first unlock address begins a sequence. Any other write aborts. An abort returns to idle and sets `rd_mode` to 0.
- R3: The second cycle must write 0x55 to the captured second unlock address. Any other write aborts. Later changes on the configuration pins have no effect until the next reset.
- R4: The third (command) cycle must target the first unlock address, or the sequence aborts. The commands are: 0x90 sets `rd_mode` to 1 (identification), 0x98 sets `rd_mode` to 2 (query), 0xA0 starts a program, 0x80 starts an erase, and 0x20 turns bypass on. Any other value aborts.
- R5: In idle, a write of 0x98 to any address sets `rd_mode` to 2 without any unlock cycles. A valid first unlock write (0xAA at the first address) leaves `rd_mode` unchanged.
- R6: After 0xA0, the next write raises `prog_req` and `busy` and captures its offset into `prog_off` and its data into `prog_data`. These hold steady until a cycle in which `prog_ack` is high, after which the machine is idle. Writes made while `busy` is high are ignored.
- R7: After 0x80, the block expects 0xAA at the first address, then 0x55 at the second, then a final cycle. A final 0x30 at any address raises `erase_req`, with `erase_chip` = 0 and `erase_sector` = `wr_off[ADDR_W-1:SECT_LSB]`. A final 0x10 at the first address raises `erase_req` with `erase_chip` = 1. Any other final cycle aborts. The request holds until `erase_ack`.
- R8: A write of 0xF0 in any state except busy returns to idle with `rd_mode` = 0. It does not change bypass mode.
- R9: With bypass on, an idle write of 0xA0 at any address starts a program (as in R6). A write of 0x90 followed by a write of 0x00 turns bypass off. Other idle writes are ignored.
- R10: `rd_data` is registered from `rd_off` and the current mode with one cycle of latency. In mode 2 it returns query entry `rd_off`, zero-extended. Entries 0, 1 and 2 are 0x51, 0x52 and 0x59 ("QRY"), entry 3 is 0x02, and offsets at or beyond `QRY_LEN` read 0. In mode 1 it returns identification word `rd_off[1:0]`. In mode 0 it returns 0.
- R11: `prog_req` and `erase_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; unlock addresses sampled while high |
| cfg_unlock0 | input | ADDR_W | First unlock address, captured during reset |
| cfg_unlock1 | input | ADDR_W | Second unlock address, captured during reset |
| wr_vld | input | 1 | One-cycle write strobe |
| wr_off | input | ADDR_W | Byte offset of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_off | input | ADDR_W | Read offset for query and identification reads |
| rd_mode | output | 2 | Read mode: 0 array, 1 identification, 2 query |
| rd_data | output | 16 | Registered read data for the current mode |
| prog_req | output | 1 | Program request, held until acknowledged |
| prog_off | output | ADDR_W | Offset to program |
| prog_data | output | 8 | Byte to program |
| prog_ack | input | 1 | Storage side has finished the program |
| erase_req | output | 1 | Erase request, held until acknowledged |
| erase_chip | output | 1 | 1 for whole-chip erase, 0 for sector erase |
| erase_sector | output | ADDR_W-SECT_LSB | Sector selected by the upper offset bits |
| erase_ack | input | 1 | Storage side has finished the erase |
| busy | output | 1 | A program or erase request is outstanding |

## Verification
The bench builds the block with `ADDR_W` = 12 and `SECT_LSB` = 8. At these values the usual 0x555/0x2AA unlock pair fits the offset, and the upper nibble of a test offset selects one of 16 sectors. Distinct non-zero identification words make a wrong word index visible. The bench also resets a second time with a different unlock pair (0x0AB/0x154) and then moves the configuration pins away. This shows that the address checks follow the values captured at reset and not fixed constants or live pins. The default `QRY_LEN` puts offset 0x52 past the end of the query table, so the bench can read that boundary.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_UNL1     = 4'd1,
    ST_CMD      = 4'd2,
    ST_ER_U0    = 4'd3,
    ST_ER_U1    = 4'd4,
    ST_ER_CONF  = 4'd5,
    ST_PGM_DATA = 4'd6,
    ST_BUSY     = 4'd7,
    ST_BYP_EXIT = 4'd8
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_ID    = 2'd1,
    MODE_QUERY = 2'd2
  } rd_mode_e;

  localparam logic [7:0] DAT_UNL_A   = 8'hAA;
  localparam logic [7:0] DAT_UNL_B   = 8'h55;
  localparam logic [7:0] DAT_RESET   = 8'hF0;
  localparam logic [7:0] DAT_QUERY   = 8'h98;
  localparam logic [7:0] DAT_IDENT   = 8'h90;
  localparam logic [7:0] DAT_PROG    = 8'hA0;
  localparam logic [7:0] DAT_ERASE   = 8'h80;
  localparam logic [7:0] DAT_BYP_ON  = 8'h20;
  localparam logic [7:0] DAT_BYP_OFF = 8'h00;
  localparam logic [7:0] DAT_SECT    = 8'h30;
  localparam logic [7:0] DAT_CHIP    = 8'h10;

  // Query table content, computed per index rather than stored as a list.
  function automatic logic [7:0] query_entry(input int unsigned idx,
                                             input logic [7:0] size_log2);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h51;
      1:       v = 8'h52;
      2:       v = 8'h59;
      3:       v = 8'h02;
      23:      v = size_log2;
      28:      v = 8'h01;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nor_unlock_cfg.sv
module nor_unlock_cfg #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_unlock0,
  input  logic [ADDR_W-1:0] cfg_unlock1,
  input  logic [ADDR_W-1:0] wr_off,
  output logic              hit0,
  output logic              hit1
);

  logic [ADDR_W-1:0] u0_q;
  logic [ADDR_W-1:0] u1_q;

  // Unlock addresses are loaded only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      u0_q <= cfg_unlock0;
      u1_q <= cfg_unlock1;
    end
  end

  assign hit0 = (wr_off == u0_q);
  assign hit1 = (wr_off == u1_q);

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SECT_LSB = 8,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_off,
  input  logic [7:0]        wr_data,
  input  logic              hit0,
  input  logic              hit1,
  input  logic              prog_ack,
  input  logic              erase_ack,
  output logic [1:0]        mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_off,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sector,
  output logic              busy
);

  seq_state_e        st_q, st_d;
  rd_mode_e          mode_q, mode_d;
  logic              byp_q, byp_d;
  logic              pr_q, pr_d;
  logic [ADDR_W-1:0] poff_q, poff_d;
  logic [7:0]        pdat_q, pdat_d;
  logic              er_q, er_d;
  logic              ech_q, ech_d;
  logic [SECT_W-1:0] esec_q, esec_d;
  logic              abort;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    byp_d  = byp_q;
    pr_d   = pr_q;
    poff_d = poff_q;
    pdat_d = pdat_q;
    er_d   = er_q;
    ech_d  = ech_q;
    esec_d = esec_q;
    abort  = 1'b0;

    if (st_q == ST_BUSY) begin
      // Writes are ignored here; only acknowledges move the machine.
      if (pr_q && prog_ack) begin
        pr_d = 1'b0;
        st_d = ST_IDLE;
      end
      if (er_q && erase_ack) begin
        er_d  = 1'b0;
        ech_d = 1'b0;
        st_d  = ST_IDLE;
      end
    end else if (wr_vld) begin
      if (wr_data == DAT_RESET) begin
        st_d   = ST_IDLE;
        mode_d = MODE_ARRAY;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (wr_data == DAT_QUERY) begin
              mode_d = MODE_QUERY;
            end else if (byp_q) begin
              if (wr_data == DAT_PROG)       st_d = ST_PGM_DATA;
              else if (wr_data == DAT_IDENT) st_d = ST_BYP_EXIT;
            end else if (hit0 && wr_data == DAT_UNL_A) begin
              st_d = ST_UNL1;
            end else begin
              abort = 1'b1;
            end
          end
          ST_UNL1: begin
            if (hit1 && wr_data == DAT_UNL_B) st_d = ST_CMD;
            else                              abort = 1'b1;
          end
          ST_CMD: begin
            if (!hit0) begin
              abort = 1'b1;
            end else begin
              case (wr_data)
                DAT_IDENT: begin
                  mode_d = MODE_ID;
                  st_d   = ST_IDLE;
                end
                DAT_QUERY: begin
                  mode_d = MODE_QUERY;
                  st_d   = ST_IDLE;
                end
                DAT_PROG:  st_d = ST_PGM_DATA;
                DAT_ERASE: st_d = ST_ER_U0;
                DAT_BYP_ON: begin
                  byp_d  = 1'b1;
                  mode_d = MODE_ARRAY;
                  st_d   = ST_IDLE;
                end
                default: abort = 1'b1;
              endcase
            end
          end
          ST_ER_U0: begin
            if (hit0 && wr_data == DAT_UNL_A) st_d = ST_ER_U1;
            else                              abort = 1'b1;
          end
          ST_ER_U1: begin
            if (hit1 && wr_data == DAT_UNL_B) st_d = ST_ER_CONF;
            else                              abort = 1'b1;
          end
          ST_ER_CONF: begin
            if (wr_data == DAT_SECT) begin
              er_d   = 1'b1;
              ech_d  = 1'b0;
              esec_d = wr_off[ADDR_W-1:SECT_LSB];
              st_d   = ST_BUSY;
            end else if (wr_data == DAT_CHIP && hit0) begin
              er_d  = 1'b1;
              ech_d = 1'b1;
              st_d  = ST_BUSY;
            end else begin
              abort = 1'b1;
            end
          end
          ST_PGM_DATA: begin
            pr_d   = 1'b1;
            poff_d = wr_off;
            pdat_d = wr_data;
            st_d   = ST_BUSY;
          end
          ST_BYP_EXIT: begin
            if (wr_data == DAT_BYP_OFF) byp_d = 1'b0;
            st_d = ST_IDLE;
          end
          default: abort = 1'b1;
        endcase
        if (abort) begin
          st_d   = ST_IDLE;
          mode_d = MODE_ARRAY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_ARRAY;
      byp_q  <= 1'b0;
      pr_q   <= 1'b0;
      poff_q <= '0;
      pdat_q <= '0;
      er_q   <= 1'b0;
      ech_q  <= 1'b0;
      esec_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      byp_q  <= byp_d;
      pr_q   <= pr_d;
      poff_q <= poff_d;
      pdat_q <= pdat_d;
      er_q   <= er_d;
      ech_q  <= ech_d;
      esec_q <= esec_d;
    end
  end

  assign mode         = mode_q;
  assign prog_req     = pr_q;
  assign prog_off     = poff_q;
  assign prog_data    = pdat_q;
  assign erase_req    = er_q;
  assign erase_chip   = ech_q;
  assign erase_sector = esec_q;
  assign busy         = pr_q | er_q;

endmodule

// File: rtl/nor_id_rom.sv
module nor_id_rom
  import nor_cmd_pkg::*;
#(
  parameter int                 ADDR_W    = 12,
  parameter int unsigned        QRY_LEN   = 82,
  parameter int                 ID_CNT    = 4,
  parameter logic [ID_CNT-1:0][15:0] ID_WORDS = '0,
  parameter logic [7:0]         SIZE_LOG2 = 8'd21,
  localparam int                ID_SEL_W  = (ID_CNT > 1) ? $clog2(ID_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] rd_off,
  output logic [15:0]       rd_data
);

  logic [15:0] qry_word;
  logic [15:0] id_word;

  always_comb begin
    if (32'(rd_off) < QRY_LEN) qry_word = {8'h00, query_entry(32'(rd_off), SIZE_LOG2)};
    else                       qry_word = 16'h0000;
  end

  generate
    if (ID_CNT > 1) begin : g_id_multi
      assign id_word = ID_WORDS[rd_off[ID_SEL_W-1:0]];
    end else begin : g_id_single
      assign id_word = ID_WORDS[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 16'h0000;
    end else begin
      case (mode)
        MODE_QUERY: rd_data <= qry_word;
        MODE_ID:    rd_data <= id_word;
        default:    rd_data <= 16'h0000;
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int                ADDR_W    = 12,
  parameter int                SECT_LSB  = 8,
  parameter int unsigned       QRY_LEN   = 82,
  parameter logic [3:0][15:0]  ID_WORDS  = {16'h0000, 16'h0000, 16'h2249, 16'h00C2},
  parameter logic [7:0]        SIZE_LOG2 = 8'd21,
  localparam int               SECT_W    = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_unlock0,
  input  logic [ADDR_W-1:0] cfg_unlock1,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_off,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_off,
  output logic [1:0]        rd_mode,
  output logic [15:0]       rd_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_off,
  output logic [7:0]        prog_data,
  input  logic              prog_ack,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sector,
  input  logic              erase_ack,
  output logic              busy
);

  logic hit0;
  logic hit1;

  nor_unlock_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cfg_unlock0 (cfg_unlock0),
    .cfg_unlock1 (cfg_unlock1),
    .wr_off      (wr_off),
    .hit0        (hit0),
    .hit1        (hit1)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_vld       (wr_vld),
    .wr_off       (wr_off),
    .wr_data      (wr_data),
    .hit0         (hit0),
    .hit1         (hit1),
    .prog_ack     (prog_ack),
    .erase_ack    (erase_ack),
    .mode         (rd_mode),
    .prog_req     (prog_req),
    .prog_off     (prog_off),
    .prog_data    (prog_data),
    .erase_req    (erase_req),
    .erase_chip   (erase_chip),
    .erase_sector (erase_sector),
    .busy         (busy)
  );

  nor_id_rom #(
    .ADDR_W    (ADDR_W),
    .QRY_LEN   (QRY_LEN),
    .ID_CNT    (4),
    .ID_WORDS  (ID_WORDS),
    .SIZE_LOG2 (SIZE_LOG2)
  ) u_rom (
    .clk     (clk),
    .rst     (rst),
    .mode    (rd_mode),
    .rd_off  (rd_off),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W   = 12,
  parameter int SECT_LSB = 8,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_vld,
  input logic [7:0]        wr_data,
  input logic [1:0]        rd_mode,
  input logic              prog_req,
  input logic [ADDR_W-1:0] prog_off,
  input logic [7:0]        prog_data,
  input logic              prog_ack,
  input logic              erase_req,
  input logic              erase_chip,
  input logic [SECT_W-1:0] erase_sector,
  input logic              erase_ack,
  input logic              busy
);

  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !prog_ack) |=> (prog_req && $stable(prog_off) && $stable(prog_data))); // R6

  AST_PROG_DROP: assert property (@(posedge clk) disable iff (rst)
    (prog_req && prog_ack) |=> !prog_req); // R6

  AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_ack) |=> (erase_req && $stable(erase_sector) && $stable(erase_chip))); // R7

  AST_ERASE_DROP: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_ack) |=> !erase_req); // R7

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(prog_req && erase_req)); // R11

  AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_data == 8'hF0 && !busy) |=> (rd_mode == 2'd0)); // R8

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rd_mode != 2'd3); // R10

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_vld       (wr_vld),
  .wr_data      (wr_data),
  .rd_mode      (rd_mode),
  .prog_req     (prog_req),
  .prog_off     (prog_off),
  .prog_data    (prog_data),
  .prog_ack     (prog_ack),
  .erase_req    (erase_req),
  .erase_chip   (erase_chip),
  .erase_sector (erase_sector),
  .erase_ack    (erase_ack),
  .busy         (busy)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int SECT_LSB   = 8;
  localparam int SECT_W     = ADDR_W - SECT_LSB;
  localparam int WDOG_CYC   = 20000;
  localparam logic [3:0][15:0] IDS = {16'hD004, 16'hC003, 16'hB002, 16'hA001};

  // vector: offset[23:12] data[11:4] mode[3:2] prog[1] erase[0]
  localparam int NVEC = 32;
  localparam logic [23:0] VEC [NVEC] = '{
    {12'h000, 8'h98, 2'd2, 1'b0, 1'b0},
    {12'h555, 8'hF0, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'h90, 2'd1, 1'b0, 1'b0},
    {12'h123, 8'hF0, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hA0, 2'd0, 1'b0, 1'b0},
    {12'h7A3, 8'h3C, 2'd0, 1'b1, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AB, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'h90, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h554, 8'h98, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'h80, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h3C5, 8'h30, 2'd0, 1'b0, 1'b1},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'h80, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd0, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd0, 1'b0, 1'b0},
    {12'h556, 8'h10, 2'd0, 1'b0, 1'b0},
    {12'h555, 8'h98, 2'd2, 1'b0, 1'b0},
    {12'h555, 8'hAA, 2'd2, 1'b0, 1'b0},
    {12'h2AA, 8'h55, 2'd2, 1'b0, 1'b0},
    {12'h555, 8'h90, 2'd1, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] cfg_unlock0 = 12'h555;
  logic [ADDR_W-1:0] cfg_unlock1 = 12'h2AA;
  logic              wr_vld = 1'b0;
  logic [ADDR_W-1:0] wr_off = '0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] rd_off = '0;
  logic [1:0]        rd_mode;
  logic [15:0]       rd_data;
  logic              prog_req;
  logic [ADDR_W-1:0] prog_off;
  logic [7:0]        prog_data;
  logic              prog_ack = 1'b0;
  logic              erase_req;
  logic              erase_chip;
  logic [SECT_W-1:0] erase_sector;
  logic              erase_ack = 1'b0;
  logic              busy;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(
    .ADDR_W   (ADDR_W),
    .SECT_LSB (SECT_LSB),
    .ID_WORDS (IDS)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_unlock0  (cfg_unlock0),
    .cfg_unlock1  (cfg_unlock1),
    .wr_vld       (wr_vld),
    .wr_off       (wr_off),
    .wr_data      (wr_data),
    .rd_off       (rd_off),
    .rd_mode      (rd_mode),
    .rd_data      (rd_data),
    .prog_req     (prog_req),
    .prog_off     (prog_off),
    .prog_data    (prog_data),
    .prog_ack     (prog_ack),
    .erase_req    (erase_req),
    .erase_chip   (erase_chip),
    .erase_sector (erase_sector),
    .erase_ack    (erase_ack),
    .busy         (busy)
  );

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1);
    rst = 1'b1;
    cfg_unlock0 = a0;
    cfg_unlock1 = a1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] off, input logic [7:0] dat);
    wr_vld  = 1'b1;
    wr_off  = off;
    wr_data = dat;
    @(negedge clk);
    wr_vld  = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] off, input logic [15:0] exp,
                        input string what);
    rd_off = off;
    @(negedge clk);
    check(rd_data == exp, what, 32'(rd_data), 32'(exp));
  endtask

  task automatic ack_prog();
    prog_ack = 1'b1;
    @(negedge clk);
    prog_ack = 1'b0;
    check(!prog_req && !busy, "R6 prog_req drops after ack", 32'(prog_req), 0);
  endtask

  task automatic ack_erase();
    erase_ack = 1'b1;
    @(negedge clk);
    erase_ack = 1'b0;
    check(!erase_req && !busy, "R7 erase_req drops after ack", 32'(erase_req), 0);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(12'h555, 12'h2AA);

    // R1 reset state
    check(rd_mode == 2'd0, "R1 rd_mode after reset", 32'(rd_mode), 0);
    check(!prog_req && !erase_req && !busy, "R1 requests idle after reset",
          {29'd0, prog_req, erase_req, busy}, 0);
    check(rd_data == 16'h0, "R1 rd_data after reset", 32'(rd_data), 0);

    // vector walk: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:12], VEC[i][11:4]);
      check(rd_mode == VEC[i][3:2] && prog_req == VEC[i][1] && erase_req == VEC[i][0],
            $sformatf("vector %0d mode/prog/erase (R2 R3 R4 R5 R7 R8)", i),
            {28'd0, rd_mode, prog_req, erase_req}, {28'd0, VEC[i][3:0]});
      if (VEC[i][1]) ack_prog();
      if (VEC[i][0]) ack_erase();
    end

    // R10 query and identification reads
    wr(12'h000, 8'hF0);
    wr(12'h0FF, 8'h98);
    rd_chk(12'h000, 16'h0051, "R10 query entry 0");
    rd_chk(12'h001, 16'h0052, "R10 query entry 1");
    rd_chk(12'h002, 16'h0059, "R10 query entry 2");
    rd_chk(12'h003, 16'h0002, "R10 query entry 3");
    rd_chk(12'h052, 16'h0000, "R10 query past end");
    unlock();
    wr(12'h555, 8'h90);
    rd_chk(12'h000, 16'hA001, "R10 id word 0");
    rd_chk(12'h003, 16'hD004, "R10 id word 3");
    wr(12'h000, 8'hF0);
    rd_chk(12'h001, 16'h0000, "R10 array mode reads zero");

    // R6 program hold and busy writes ignored
    unlock();
    wr(12'h555, 8'hA0);
    wr(12'h0F0, 8'h2C);
    repeat (4) @(negedge clk);
    check(prog_req && busy, "R6 prog_req held without ack", 32'(prog_req), 1);
    check(prog_off == 12'h0F0 && prog_data == 8'h2C, "R6 prog offset/data",
          {12'd0, prog_off, prog_data}, {12'd0, 12'h0F0, 8'h2C});
    wr(12'h555, 8'hAA);
    check(prog_data == 8'h2C, "R6 write during busy ignored", 32'(prog_data), 32'h2C);
    ack_prog();
    wr(12'h2AA, 8'h55);
    wr(12'h555, 8'h90);
    check(rd_mode == 2'd0, "R6 busy-time unlock was not taken", 32'(rd_mode), 0);

    // R7 sector and chip erase
    unlock(); wr(12'h555, 8'h80); unlock();
    wr(12'h3C5, 8'h30);
    check(erase_req && !erase_chip && erase_sector == 4'h3, "R7 sector erase",
          {29'd0, erase_req, erase_chip, 1'b0} | 32'(erase_sector) << 4, 32'h34);
    ack_erase();
    unlock(); wr(12'h555, 8'h80); unlock();
    wr(12'h555, 8'h10);
    check(erase_req && erase_chip && !prog_req, "R7 chip erase R11",
          {30'd0, erase_req, erase_chip}, 32'h3);
    ack_erase();

    // R9 bypass, and R8 leaves bypass alone
    unlock();
    wr(12'h555, 8'h20);
    wr(12'h321, 8'hA0);
    wr(12'h010, 8'h5A);
    check(prog_req && prog_off == 12'h010 && prog_data == 8'h5A, "R9 bypass program",
          {11'd0, prog_req, prog_off, prog_data}, {11'd0, 1'b1, 12'h010, 8'h5A});
    ack_prog();
    wr(12'h000, 8'hF0);
    wr(12'h654, 8'hA0);
    wr(12'h011, 8'h66);
    check(prog_req && prog_data == 8'h66, "R8 reset keeps bypass", 32'(prog_data), 32'h66);
    ack_prog();
    wr(12'h000, 8'h90);
    wr(12'h000, 8'h00);
    wr(12'h555, 8'hA0);
    wr(12'h010, 8'h77);
    check(!prog_req, "R9 bypass exit stops direct program", 32'(prog_req), 0);

    // R3 configured unlock pair captured at reset
    do_reset(12'h0AB, 12'h154);
    cfg_unlock0 = 12'h555;
    cfg_unlock1 = 12'h2AA;
    unlock();
    wr(12'h555, 8'h90);
    check(rd_mode == 2'd0, "R2 default pair rejected after custom reset", 32'(rd_mode), 0);
    wr(12'h0AB, 8'hAA);
    wr(12'h154, 8'h55);
    wr(12'h0AB, 8'h90);
    check(rd_mode == 2'd1, "R3 custom pair accepted", 32'(rd_mode), 1);
    rd_chk(12'h001, 16'hB002, "R10 id word 1 after custom unlock");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule